// File: doc/BRIEF.md
# Sample-Queued Pulse-Width Modulator

This block generates a pulse-width-modulated output. An up-counter repeats a period set by software, and each period takes its duty value from a four-entry sample queue. The output is high from the start of a period and falls once the counter reaches the duty value that is active for that period. Software sets up the block through a small register bus with an address, write data, a write strobe, a read strobe and registered read data.

A duty write never changes the compare value of the period that is already running. This holds even when the queue is empty. A new value can only become active at a period boundary, so lowering the duty can never make a period stay high from start to end because its falling edge was skipped. When the queue is empty at a boundary, the previous duty is used again. Writes that arrive while the queue is full are dropped and recorded in a sticky flag.

Register offsets: control 0x00, status 0x04, sample 0x0C, period 0x10, live counter 0x14.

Top module: `pwmf_top`

## Requirements
- R1: After reset, `pwm_out` is low and reads of status, control, period and counter all return 0.
- R2: While running, the counter steps from 0 up to the period value (offset 0x10) and then returns to 0, so one period lasts period+1 cycles. `pwm_out` is high exactly while the counter is below the active duty value.
- R3: The sample queue holds four entries, written at offset 0x0C. At each period start one entry is moved into the active duty register, oldest first.
- R4: If the queue is empty at a period start, the active duty value stays unchanged for the new period.
- R5: A sample write while four entries are queued is discarded and sets the sticky overflow flag in status bit 4. Writing 1 to status bit 4 clears the flag.
- R6: Status bits 2:0 report the number of queued samples, from 0 to 4.
- R7: A sample write never changes the active duty value in the middle of a period. With an empty queue, the new value takes effect at the next period start, including when the counter has already passed the new value.
- R8: A duty of 0 keeps `pwm_out` low for the whole period. A duty above the period value keeps it high for the whole period.
- R9: Control bit 0 is the enable. Setting it starts a period with the counter at 0 and loads the oldest queued sample. While it is clear, `pwm_out` is low and the counter reads 0. A control write with bit 0 clear empties the queue.
- R10: The period register reads back its written value. Offset 0x14 returns the live counter value. Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled high.
- R11: Control bits 27:26 form a watermark field that is stored and read back. It has no effect on `pwm_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 1 | Modulated output |

## Verification
The main target is the mid-period duty decrease with an empty queue. A new value is written after the counter has already passed it. A design that loads the value at once would hold the output high for the whole period, and the bench records every output cycle of that period. A second case writes the smaller value before the counter has reached it. A design that updates immediately would then fall early, so the bench also catches that.

Other cases:
- The fifth write into a full queue. A design that overwrites a queued entry would show the wrong duty order.
- Reuse of the last duty after the queue runs dry. A design that loads zero here would drop the output to constant low.
- Duties of 0 and of values above the period, where a wrong compare edge gives a one-cycle glitch.
- Disabling while running, which must empty the queue and return the counter to 0.

// File: rtl/pwmf_pkg.sv
// Package: shared register offsets, field positions and widths for the
// sample-queued PWM. Assumes a byte-addressed 8-bit offset space.
package pwmf_pkg;
    localparam int AW = 8;
    localparam int BW = 32;

    localparam logic [AW-1:0] OFS_CTRL = 8'h00;
    localparam logic [AW-1:0] OFS_STAT = 8'h04;
    localparam logic [AW-1:0] OFS_DUTY = 8'h0C;
    localparam logic [AW-1:0] OFS_PRD  = 8'h10;
    localparam logic [AW-1:0] OFS_CNT  = 8'h14;

    localparam int EN_BIT  = 0;
    localparam int WM_LO   = 26;
    localparam int WM_HI   = 27;
    localparam int OVF_BIT = 4;
endpackage

// File: rtl/pwmf_fifo.sv
// Module: pwmf_fifo
// Small circular queue of duty samples. A push into a full queue is
// dropped and a pop from an empty queue is ignored. Flush takes priority
// over push and pop. Assumes DEPTH is a power of two.
module pwmf_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          push_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    // Status decode and qualified push/pop.
    always_comb begin
        full_o  = (cnt_q == CW'(DEPTH));
        empty_o = (cnt_q == '0);
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        head_o  = mem_q[rd_ptr_q];
        count_o = cnt_q;
    end

    // Storage write; entries need no reset because reads are count-gated.
    always_ff @(posedge clk) begin
        if (do_push && !flush_i) begin
            mem_q[wr_ptr_q] <= wdata_i;
        end
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    p_fifo_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    p_drop_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i && !flush_i) |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/pwmf_core.sv
// Module: pwmf_core
// Period counter and active duty register. The active value is loaded
// only at a period boundary (enable start or counter wrap), so a new
// sample never changes the period in progress. Output is high while the
// counter is below the active duty.
module pwmf_core #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [DW-1:0] period_i,
    input  logic [DW-1:0] head_i,
    input  logic          fifo_empty_i,
    output logic          pop_o,
    output logic [DW-1:0] cnt_o,
    output logic          pwm_o
);
    logic          run_q;
    logic [DW-1:0] cnt_q, act_q;
    logic          start, wrap, boundary;

    // Period boundary detection and queue pop request.
    always_comb begin
        start    = en_i && !run_q;
        wrap     = en_i && run_q && (cnt_q >= period_i);
        boundary = start || wrap;
        pop_o    = boundary && !fifo_empty_i;
    end

    // Counter, run flag and active duty update.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            act_q <= '0;
        end else begin
            run_q <= 1'b1;
            cnt_q <= boundary ? '0 : cnt_q + 1'b1;
            if (pop_o) act_q <= head_i;
        end
    end

    // Output compare.
    always_comb begin
        pwm_o = run_q && (cnt_q < act_q);
        cnt_o = cnt_q;
    end

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && run_q && cnt_q >= period_i) |=> (cnt_q == '0));

    p_reuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && fifo_empty_i) |=> $stable(act_q));

    p_act_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != '0) |-> $stable(act_q));

    p_fall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != '0 && $past(run_q) && !$past(pwm_o)) |-> !pwm_o);

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0 && !pwm_o));
endmodule

// File: rtl/pwmf_regs.sv
// Module: pwmf_regs
// Register decode: control, status (occupancy and sticky overflow with
// write-one-to-clear), sample push, period and live counter readout.
// Read data is registered on the read strobe.
module pwmf_regs
    import pwmf_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic [BW-1:0] wdata_i,
    input  logic          wr_i,
    input  logic          rd_i,
    output logic [BW-1:0] rdata_o,
    output logic          en_o,
    output logic [DW-1:0] period_o,
    output logic          flush_o,
    output logic          push_o,
    output logic [DW-1:0] sample_o,
    input  logic [CW-1:0] fifo_cnt_i,
    input  logic          fifo_full_i,
    input  logic [DW-1:0] cnt_i
);
    logic          en_q, ovf_q, ovf_clr;
    logic [1:0]    wm_q;
    logic [DW-1:0] prd_q;
    logic [BW-1:0] rd_mux;

    // Write-side strobes.
    always_comb begin
        flush_o  = wr_i && (addr_i == OFS_CTRL) && !wdata_i[EN_BIT];
        push_o   = wr_i && (addr_i == OFS_DUTY);
        sample_o = wdata_i[DW-1:0];
        ovf_clr  = wr_i && (addr_i == OFS_STAT) && wdata_i[OVF_BIT];
        en_o     = en_q;
        period_o = prd_q;
    end

    // Control and period storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            wm_q  <= '0;
            prd_q <= '0;
        end else if (wr_i) begin
            if (addr_i == OFS_CTRL) begin
                en_q <= wdata_i[EN_BIT];
                wm_q <= wdata_i[WM_HI:WM_LO];
            end
            if (addr_i == OFS_PRD) prd_q <= wdata_i[DW-1:0];
        end
    end

    // Sticky overflow flag: set on dropped push, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ovf_q <= 1'b0;
        else if (push_o && fifo_full_i) ovf_q <= 1'b1;
        else if (ovf_clr)               ovf_q <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        rd_mux = '0;
        case (addr_i)
            OFS_CTRL: begin
                rd_mux[EN_BIT]      = en_q;
                rd_mux[WM_HI:WM_LO] = wm_q;
            end
            OFS_STAT: begin
                rd_mux[CW-1:0]  = fifo_cnt_i;
                rd_mux[OVF_BIT] = ovf_q;
            end
            OFS_PRD:  rd_mux[DW-1:0] = prd_q;
            OFS_CNT:  rd_mux[DW-1:0] = cnt_i;
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_o <= '0;
        else if (rd_i) rdata_o <= rd_mux;
    end

    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);

    p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && fifo_full_i) |=> ovf_q);
endmodule

// File: rtl/pwmf_top.sv
// Module: pwmf_top
// Sample-queued PWM: register interface, four-entry duty queue and the
// period counter with boundary-only duty loading.
module pwmf_top
    import pwmf_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [31:0]   bus_rdata,
    output logic          pwm_out
);
    logic          en, flush, push, pop, full, empty;
    logic [DW-1:0] period, sample, head, cnt;
    logic [CW-1:0] fcount;

    pwmf_regs #(.DW(DW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .wr_i       (bus_wr),
        .rd_i       (bus_rd),
        .rdata_o    (bus_rdata),
        .en_o       (en),
        .period_o   (period),
        .flush_o    (flush),
        .push_o     (push),
        .sample_o   (sample),
        .fifo_cnt_i (fcount),
        .fifo_full_i(full),
        .cnt_i      (cnt)
    );

    pwmf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush),
        .push_i  (push),
        .wdata_i (sample),
        .pop_i   (pop),
        .head_o  (head),
        .count_o (fcount),
        .full_o  (full),
        .empty_o (empty)
    );

    pwmf_core #(.DW(DW)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .period_i    (period),
        .head_i      (head),
        .fifo_empty_i(empty),
        .pop_o       (pop),
        .cnt_o       (cnt),
        .pwm_o       (pwm_out)
    );

    p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_out);

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fcount == '0));
endmodule

// File: tb/tb_pwmf_top.sv
`timescale 1ns/1ps
module tb_pwmf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        pwm_out;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_DUTY = 8'h0C,
                           A_PRD = 8'h10, A_CNT = 8'h14;

    pwmf_top dut (.*);

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    // Called right after the enabling write; checks np periods of output.
    task automatic run_wave(input string req, input int p, input int np,
                            input int d [5], input int wc, input int wv,
                            input int rc);
        int plen = p + 1;
        for (int k = 0; k < np; k++) begin
            int hi = 0;
            int mism = 0;
            int eh = (d[k] < plen) ? d[k] : plen;
            for (int c = 0; c < plen; c++) begin
                int g = k * plen + c;
                @(negedge clk);
                if (pwm_out) hi++;
                if (pwm_out != (c < eh)) mism++;
                if (g == wc + 1 || g == rc + 1) begin
                    bus_wr = 1'b0;
                    bus_rd = 1'b0;
                end
                if (g == rc + 1)
                    chk(bus_rdata == 32'(rc % plen), "R10", "live counter read",
                        bus_rdata, rc % plen);
                if (g == wc) begin
                    bus_addr = A_DUTY; bus_wdata = wv; bus_wr = 1'b1;
                end
                if (g == rc) begin
                    bus_addr = A_CNT; bus_rd = 1'b1;
                end
            end
            chk(mism == 0 && hi == eh, req, $sformatf("high cycles period %0d", k),
                hi, eh);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk(pwm_out == 1'b0, "R1", "output after reset", pwm_out, 0);
        bus_read(A_STAT, v); chk(v == 0, "R1", "status after reset", v, 0);
        bus_read(A_CNT, v);  chk(v == 0, "R1", "counter after reset", v, 0);
        bus_read(A_CTRL, v); chk(v == 0, "R1", "control after reset", v, 0);
    endtask

    task automatic t_order();
        logic [31:0] v;
        bus_write(A_CTRL, 0);
        bus_write(A_PRD, 9);
        bus_read(A_PRD, v); chk(v == 9, "R10", "period readback", v, 9);
        bus_write(A_DUTY, 2); bus_write(A_DUTY, 5);
        bus_write(A_DUTY, 8); bus_write(A_DUTY, 1);
        bus_write(A_CTRL, 1);
        // R3 order, R4 reuse in the fifth period, R2 period length
        run_wave("R3", 9, 5, '{2, 5, 8, 1, 1}, -5, 0, 13);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        bus_write(A_CTRL, 0);
        for (int i = 3; i <= 7; i++) bus_write(A_DUTY, i);
        bus_read(A_STAT, v);
        chk(v[2:0] == 4, "R6", "occupancy when full", v[2:0], 4);
        chk(v[4] == 1'b1, "R5", "overflow flag set", v[4], 1);
        bus_write(A_CTRL, 1);
        run_wave("R5", 9, 5, '{3, 4, 5, 6, 6}, -5, 0, -5);
        bus_write(A_STAT, 32'h10);
        bus_read(A_STAT, v);
        chk(v[4] == 1'b0, "R5", "overflow flag cleared", v[4], 0);
    endtask

    task automatic t_mid_decrease();
        bus_write(A_CTRL, 0);
        bus_write(A_DUTY, 6);
        bus_write(A_CTRL, 1);
        // counter already past the new value when it is written
        run_wave("R7", 9, 3, '{6, 3, 3, 0, 0}, 7, 3, -5);
        bus_write(A_CTRL, 0);
        bus_write(A_DUTY, 6);
        bus_write(A_CTRL, 1);
        // counter still below the new value when it is written
        run_wave("R7", 9, 2, '{6, 3, 0, 0, 0}, 1, 3, -5);
    endtask

    task automatic t_extremes();
        bus_write(A_CTRL, 0);
        bus_write(A_DUTY, 0); bus_write(A_DUTY, 15); bus_write(A_DUTY, 10);
        bus_write(A_DUTY, 0);
        bus_write(A_CTRL, 1);
        run_wave("R8", 9, 4, '{0, 10, 10, 0, 0}, -5, 0, -5);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        int hi = 0;
        bus_write(A_DUTY, 4); bus_write(A_DUTY, 4);
        bus_write(A_CTRL, 0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        chk(hi == 0, "R9", "output while disabled", hi, 0);
        bus_read(A_CNT, v);  chk(v == 0, "R9", "counter while disabled", v, 0);
        bus_read(A_STAT, v); chk(v[2:0] == 0, "R9", "queue flushed", v[2:0], 0);
    endtask

    task automatic t_watermark();
        logic [31:0] v;
        bus_write(A_CTRL, 32'h0800_0000);
        bus_read(A_CTRL, v);
        chk(v == 32'h0800_0000, "R11", "watermark readback", v, 32'h0800_0000);
        bus_write(A_DUTY, 4);
        bus_write(A_CTRL, 32'h0C00_0001);
        run_wave("R11", 9, 2, '{4, 4, 0, 0, 0}, -5, 0, -5);
        bus_write(A_CTRL, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_overflow();
        t_mid_decrease();
        t_extremes();
        t_disable();
        t_watermark();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule